// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block gives every hart in a cluster a 32-bit word through which any hart can raise a software interrupt on any other. Harts reach it over a plain register bus with a byte address, a write strobe, a full-word flag, write data and combinational read data. The block drives one interrupt line per hart.

A single elaboration parameter picks one of two behaviours.

In machine mode each word holds a pending level in bit 0. Software sets and clears that level, reads it back, and the level drives the hart's interrupt line directly.

In supervisor mode a word is a set-only doorbell. Writing a one sends a single-cycle set pulse toward the hart's own pending bit, which lives outside this block, and the hart clears that bit itself. In this mode every word reads as zero.

Top module: `swi_bank`

## Requirements
- R1: Word n sits at byte address 4*n. The hart index is the byte address shifted right by two.
- R2: A write acts on bit 0 of the write data only. Bits 31..1 have no effect.
- R3: In machine mode, a decoded write with bit 0 = 1 sets the hart's pending level, and bit 0 = 0 clears it. The `irq` line follows from the cycle after the write and holds until the next decoded write to that hart.
- R4: In machine mode, a decoded read returns the pending level in bit 0, and bits 31..1 read as zero.
- R5: In supervisor mode, every read returns zero.
- R6: In supervisor mode, a decoded write with bit 0 = 1 raises that hart's `irq` for exactly the next cycle. A write with bit 0 = 0 raises nothing.
- R7: An access is acted on only if it is a full word (`bus_full` = 1) and `bus_addr[1:0]` = 0. Any other access reads zero and its write is ignored.
- R8: An access whose hart index is NUM_HARTS or above reads zero and its write is ignored.
- R9: While `rst_n` is low, every `irq` line is low and every machine-mode pending level is cleared. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_full | input | 1 | Access is a full 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | NUM_HARTS | Interrupt level (machine mode) or set pulse (supervisor mode), one per hart |

## Verification
One bus drives a machine-mode copy and a supervisor-mode copy side by side, so every access shows the level rule and the pulse rule together.

The write patterns each separate one point:
- A write with only bit 0 set against a write with the upper bits set and bit 0 clear separates bit-0 decoding from whole-word decoding.
- Writes to the first and last harts confirm the stride.
- A second check in the cycle after a write tells a held level from a one-cycle pulse.
- Misaligned, half-word and out-of-range addresses aimed at harts that are already pending show whether a bad access leaks into the state.
- A reset in the middle of the run checks that all pending state is lost.

// File: rtl/swi_bank.sv
module swi_bank #(
  parameter int NUM_HARTS  = 4,
  parameter int ADDR_W     = 8,
  parameter bit SUPERVISOR = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_full,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic [NUM_HARTS-1:0] irq
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]     hart_sel;
  logic                 hit;
  logic [NUM_HARTS-1:0] sel_vec;
  logic [NUM_HARTS-1:0] state_q;
  logic                 unused_wdata;

  assign hart_sel     = bus_addr[ADDR_W-1:2];
  assign hit          = bus_full && (bus_addr[1:0] == 2'b00) && (32'(hart_sel) < NUM_HARTS);
  assign unused_wdata = ^bus_wdata[31:1];

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign sel_vec[h] = hit && (32'(hart_sel) == h);

    if (SUPERVISOR) begin : g_sup
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          state_q[h] <= 1'b0;
        else
          state_q[h] <= bus_we && sel_vec[h] && bus_wdata[0];
      end
    end else begin : g_mach
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          state_q[h] <= 1'b0;
        else if (bus_we && sel_vec[h])
          state_q[h] <= bus_wdata[0];
      end
    end
  end

  assign irq = state_q;

  if (SUPERVISOR) begin : g_rd_sup
    assign bus_rdata = 32'd0;
  end else begin : g_rd_mach
    assign bus_rdata = {31'd0, |(sel_vec & state_q)};
  end
endmodule

// File: rtl/swi_bank_chk.sv
module swi_bank_chk #(
  parameter int NUM_HARTS  = 4,
  parameter int ADDR_W     = 8,
  parameter bit SUPERVISOR = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic                 bus_we,
  input logic                 bus_full,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_HARTS-1:0] irq
);
  logic unused_chk;
  assign unused_chk = ^bus_wdata[31:1];

  assert_rd_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:1] == 31'd0);

  assert_bad_access_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_full || bus_addr[1:0] != 2'b00) |-> bus_rdata == 32'd0);

  // R1 and R6 as well: a write of one to byte address 0 reaches hart 0 on the next cycle
  assert_hart0_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_full && bus_addr == '0 && bus_wdata[0]) |=> irq[0]);

  assert_reset_low_R9: assert property (@(posedge clk) disable iff (rst_n)
    irq == '0);

  if (SUPERVISOR) begin : g_sup
    assert_sup_rd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rdata == 32'd0);
    assert_single_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(irq));
    assert_no_pulse_without_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> irq == '0);
  end else begin : g_mach
    assert_level_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(irq));
  end
endmodule

bind swi_bank swi_bank_chk #(.NUM_HARTS(NUM_HARTS), .ADDR_W(ADDR_W), .SUPERVISOR(SUPERVISOR)) u_chk (.*);

// File: tb/tb_swi_bank.sv
`timescale 1ns/1ps
module tb_swi_bank;
  localparam int NH = 4;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic          bus_we = 1'b0;
  logic          bus_full = 1'b1;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   rdata_m, rdata_s;
  logic [NH-1:0] irq_m, irq_s;

  always #2.5 clk = ~clk;

  swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SUPERVISOR(1'b0)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_full(bus_full),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_m), .irq(irq_m));

  swi_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .SUPERVISOR(1'b1)) dut_sup (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we), .bus_full(bus_full),
    .bus_wdata(bus_wdata), .bus_rdata(rdata_s), .irq(irq_s));

  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = rdata_m;
        1: act = 32'(irq_m);
        2: act = rdata_s;
        default: act = 32'(irq_s);
      endcase
      n_vec++;
      if (act !== it.exp) begin
        n_bad++;
        $display("FAIL %s (kind %0d): actual %h expected %h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  task automatic push(int kind, logic [31:0] e, string tag);
    item_t it;
    it.kind = kind; it.exp = e; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d, logic full);
    bus_addr = a; bus_wdata = d; bus_full = full; bus_we = 1'b1;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_full = 1'b1; bus_addr = '0; bus_wdata = '0;
  endtask

  task automatic chk_irq(logic [NH-1:0] em, logic [NH-1:0] es, string tag);
    push(1, 32'(em), tag);
    push(3, 32'(es), tag);
    @(posedge clk); #1;
  endtask

  task automatic rd(logic [AW-1:0] a, logic full, logic [31:0] em, string tag);
    bus_addr = a; bus_full = full;
    push(0, em, tag);
    push(2, 32'd0, {tag, " R5"});
    @(posedge clk); #1;
    bus_full = 1'b1; bus_addr = '0;
  endtask

  initial begin
    repeat (2) @(posedge clk);
    #1;
    chk_irq(4'b0000, 4'b0000, "R9 reset state");
    rd(8'h04, 1'b1, 32'd0, "R9 reset read");
    rst_n = 1'b1;
    @(posedge clk); #1;

    wr(8'h04, 32'd1, 1'b1);
    chk_irq(4'b0010, 4'b0010, "R3 R6 set hart1");
    chk_irq(4'b0010, 4'b0000, "R3 R6 level held, pulse one cycle");
    rd(8'h04, 1'b1, 32'd1, "R4 read pending");

    wr(8'h04, 32'hFFFF_FFFE, 1'b1);
    chk_irq(4'b0000, 4'b0000, "R2 R6 bit0 zero clears, no pulse");

    wr(8'h08, 32'hFFFF_FFFF, 1'b1);
    chk_irq(4'b0100, 4'b0100, "R2 all ones sets hart2");
    rd(8'h08, 1'b1, 32'd1, "R4 upper bits zero");

    wr(8'h0C, 32'd1, 1'b1);
    chk_irq(4'b1100, 4'b1000, "R1 stride hart3");
    wr(8'h00, 32'd1, 1'b1);
    chk_irq(4'b1101, 4'b0001, "R1 stride hart0");
    rd(8'h0C, 1'b1, 32'd1, "R1 read hart3");

    wr(8'h05, 32'd1, 1'b1);
    chk_irq(4'b1101, 4'b0000, "R7 misaligned write ignored");
    wr(8'h0A, 32'd0, 1'b1);
    chk_irq(4'b1101, 4'b0000, "R7 misaligned clear ignored");
    rd(8'h09, 1'b1, 32'd0, "R7 misaligned read");
    rd(8'h08, 1'b0, 32'd0, "R7 non-word read");
    wr(8'h04, 32'd1, 1'b0);
    chk_irq(4'b1101, 4'b0000, "R7 non-word write ignored");
    wr(8'h08, 32'd0, 1'b0);
    chk_irq(4'b1101, 4'b0000, "R7 non-word clear ignored");

    wr(8'h10, 32'd1, 1'b1);
    chk_irq(4'b1101, 4'b0000, "R8 hart index 4 ignored");
    wr(8'hFC, 32'd1, 1'b1);
    chk_irq(4'b1101, 4'b0000, "R8 top index ignored");
    rd(8'h10, 1'b1, 32'd0, "R8 out-of-range read");

    wr(8'h00, 32'd0, 1'b1);
    chk_irq(4'b1100, 4'b0000, "R3 clear hart0");

    rst_n = 1'b0;
    #1;
    chk_irq(4'b0000, 4'b0000, "R9 reset mid-run");
    rst_n = 1'b1;
    @(posedge clk); #1;
    rd(8'h0C, 1'b1, 32'd0, "R9 hart3 cleared");
    rd(8'h08, 1'b1, 32'd0, "R9 hart2 cleared");
    chk_irq(4'b0000, 4'b0000, "R9 stays clear");

    repeat (2) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule